// File: doc/BRIEF.md
# Privilege-Checked Flags Update Unit

This block owns the processor flags word and applies the privilege rules whenever an operation changes it. Each operation arrives as a one-cycle strobe. The strobe carries an operation code, the current privilege level, a replacement flags word and a selector. The block decides field by field which parts of the replacement word take effect. The I/O privilege field changes only at level 0 or on a task switch. The interrupt-enable bit changes only when the current level is at or below the I/O privilege field. The nested-task bit follows the restored word or the task-switch rules.

An interrupt-return is steered by the nested-task bit. When the bit is clear, the return stays inside the current task. When it is set, the return targets the task named by the supplied backlink selector. A zero backlink on that path is a protection fault.

An interrupt that does not switch tasks hands out the old nested-task value for the stack frame and then clears the bit. A task switch by call or interrupt installs the new task's flags word, sets the nested-task bit and reports the outgoing task's selector as the backlink to store. Every operation that faults leaves the flags register untouched. All results are registered and appear in the cycle after the strobe.

Top module: `flag_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the flags word becomes ONES_MASK (bit 1 with defaults). Fault, saved nested-task, return kind (0) and link output all clear.
- R2: Pop (op code 1) at level 0 loads the whole new word into the flags. This includes the I/O privilege field (bits 13:12), the interrupt bit (bit 9) and the nested-task bit (bit 14). Every bit set in ONES_MASK is forced to one on every load.
- R3: Pop, or interrupt-return (op code 2) taking the in-task path, at a level other than 0 keeps the old I/O privilege field.
- R4: Pop, or an in-task interrupt-return, keeps the old interrupt bit when the level is numerically above the old I/O privilege field. It takes the new bit otherwise.
- R5: Clear-interrupt (op code 3) and set-interrupt (op code 4) at a level at or below the I/O privilege field clear or set bit 9. No fault is raised.
- R6: Clear-interrupt or set-interrupt at a level above the I/O privilege field raises the fault and leaves the flags unchanged.
- R7: Task switch (op code 5) loads the new word at any level, with bit 14 forced to one. The link output takes `old_sel`.
- R8: Interrupt without task switch (op code 6) copies the old bit 14 to `saved_nt_q` and clears bit 14. All other bits stay as they were.
- R9: Interrupt-return with bit 14 clear reports return kind 1 (in-task) and updates the flags as a pop does.
- R10: Interrupt-return with bit 14 set and a nonzero backlink reports return kind 2 (task return). The link output takes `backlink` and the flags are unchanged.
- R11: Interrupt-return with bit 14 set and a zero backlink raises the fault, reports return kind 0 and leaves the flags unchanged.
- R12: Direct write (op code 7) at level 0 loads the new word. At any other level it raises the fault and leaves the flags unchanged.
- R13: Results appear one cycle after the strobe. The fault is a one-cycle pulse. A cycle without a strobe raises no fault and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code |
| cpl | input | 2 | Current privilege level |
| new_flags | input | FLAG_W | Replacement flags word |
| backlink | input | SEL_W | Backlink selector for interrupt-return |
| old_sel | input | SEL_W | Outgoing task selector on a task switch |
| flags_q | output | FLAG_W | Current flags word |
| fault_q | output | 1 | Protection fault pulse |
| saved_nt_q | output | 1 | Nested-task value captured for the stack frame |
| ret_kind_q | output | 2 | Return kind: 0 none, 1 in-task, 2 task return |
| link_q | output | SEL_W | Selector for backlink store or task return |

## Verification
The bench builds the block with FLAG_W and SEL_W of 16 and ONES_MASK of 16'h0002. With these values, bit 1 is an always-one bit, and the bench can watch it survive loads of zero words and direct writes. The 16-bit selectors let a zero backlink be told apart from small nonzero ones. The stimulus table walks the I/O privilege field through the values 1, 3 and 0, so both sides of every level comparison are reached from a single starting state.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_POP  = 3'd1,
    OP_IRET = 3'd2,
    OP_CLI  = 3'd3,
    OP_STI  = 3'd4,
    OP_TSW  = 3'd5,
    OP_INT  = 3'd6,
    OP_WR   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RET_NONE  = 2'd0,
    RET_LOCAL = 2'd1,
    RET_TASK  = 2'd2
  } ret_e;

  localparam int IF_POS   = 9;
  localparam int IOPL_POS = 12;
  localparam int NT_POS   = 14;
  localparam int MIN_W    = 15;
endpackage

// File: rtl/flg_priv.sv
module flg_priv (
  input  logic [1:0] cpl,
  input  logic [1:0] iopl,
  output logic       io_ok,
  output logic       ring0
);
  always_comb begin
    io_ok = (cpl <= iopl);
    ring0 = (cpl == 2'd0);
  end
endmodule

// File: rtl/flg_merge.sv
module flg_merge #(
  parameter int          W    = 16,
  parameter logic [W-1:0] ONES = '0
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] upd,
  input  logic [W-1:0] sel,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ONES[i]) begin : g_one
      assign y[i] = 1'b1;
    end else begin : g_pick
      assign y[i] = sel[i] ? upd[i] : base[i];
    end
  end
endmodule

// File: rtl/flg_next.sv
module flg_next
  import flg_pkg::*;
#(
  parameter int           W     = 16,
  parameter int           SEL_W = 16,
  parameter logic [W-1:0] ONES  = '0
) (
  input  logic [W-1:0]     cur,
  input  logic [W-1:0]     nw,
  input  logic [SEL_W-1:0] bl,
  input  logic [SEL_W-1:0] osel,
  input  logic [2:0]       op,
  input  logic [1:0]       cpl,
  output logic [W-1:0]     nxt,
  output logic             ld,
  output logic             flt,
  output logic [1:0]       ret,
  output logic             lnk_ld,
  output logic [SEL_W-1:0] lnk_val,
  output logic             snt_ld
);
  localparam logic [W-1:0] IOPL_M = W'(3) << IOPL_POS;
  localparam logic [W-1:0] IF_M   = W'(1) << IF_POS;
  localparam logic [W-1:0] NT_M   = W'(1) << NT_POS;
  localparam logic [W-1:0] ALL_M  = '1;

  logic [1:0]   iopl;
  logic         io_ok, ring0;
  logic [W-1:0] pop_sel, pop_w, full_w;
  op_e          opc;

  assign iopl = cur[IOPL_POS +: 2];
  assign opc  = op_e'(op);

  flg_priv u_priv (
    .cpl   (cpl),
    .iopl  (iopl),
    .io_ok (io_ok),
    .ring0 (ring0)
  );

  always_comb begin
    pop_sel = ALL_M;
    if (!ring0) pop_sel = pop_sel & ~IOPL_M;
    if (!io_ok) pop_sel = pop_sel & ~IF_M;
  end

  flg_merge #(.W(W), .ONES(ONES)) u_pop (
    .base (cur),
    .upd  (nw),
    .sel  (pop_sel),
    .y    (pop_w)
  );

  flg_merge #(.W(W), .ONES(ONES)) u_full (
    .base (cur),
    .upd  (nw),
    .sel  (ALL_M),
    .y    (full_w)
  );

  always_comb begin
    nxt     = cur;
    ld      = 1'b0;
    flt     = 1'b0;
    ret     = RET_NONE;
    lnk_ld  = 1'b0;
    lnk_val = osel;
    snt_ld  = 1'b0;
    unique case (opc)
      OP_POP: begin
        ld  = 1'b1;
        nxt = pop_w;
      end
      OP_IRET: begin
        if (!cur[NT_POS]) begin
          ld  = 1'b1;
          nxt = pop_w;
          ret = RET_LOCAL;
        end else if (bl == '0) begin
          flt = 1'b1;
        end else begin
          ret     = RET_TASK;
          lnk_ld  = 1'b1;
          lnk_val = bl;
        end
      end
      OP_CLI, OP_STI: begin
        if (io_ok) begin
          ld  = 1'b1;
          nxt = (opc == OP_STI) ? (cur | IF_M) : (cur & ~IF_M);
        end else begin
          flt = 1'b1;
        end
      end
      OP_TSW: begin
        ld      = 1'b1;
        nxt     = full_w | NT_M;
        lnk_ld  = 1'b1;
        lnk_val = osel;
      end
      OP_INT: begin
        ld     = 1'b1;
        nxt    = cur & ~NT_M;
        snt_ld = 1'b1;
      end
      OP_WR: begin
        if (ring0) begin
          ld  = 1'b1;
          nxt = full_w;
        end else begin
          flt = 1'b1;
        end
      end
      default: begin
        nxt = cur;
      end
    endcase
  end
endmodule

// File: rtl/flag_guard.sv
module flag_guard
  import flg_pkg::*;
#(
  parameter int                FLAG_W    = 16,
  parameter int                SEL_W     = 16,
  parameter logic [FLAG_W-1:0] ONES_MASK = FLAG_W'(2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [1:0]        cpl,
  input  logic [FLAG_W-1:0] new_flags,
  input  logic [SEL_W-1:0]  backlink,
  input  logic [SEL_W-1:0]  old_sel,
  output logic [FLAG_W-1:0] flags_q,
  output logic              fault_q,
  output logic              saved_nt_q,
  output logic [1:0]        ret_kind_q,
  output logic [SEL_W-1:0]  link_q
);
  logic [FLAG_W-1:0] nxt_c;
  logic              ld_c, flt_c, lnk_ld_c, snt_ld_c;
  logic [1:0]        ret_c;
  logic [SEL_W-1:0]  lnk_c;

  flg_next #(.W(FLAG_W), .SEL_W(SEL_W), .ONES(ONES_MASK)) u_next (
    .cur     (flags_q),
    .nw      (new_flags),
    .bl      (backlink),
    .osel    (old_sel),
    .op      (op_code),
    .cpl     (cpl),
    .nxt     (nxt_c),
    .ld      (ld_c),
    .flt     (flt_c),
    .ret     (ret_c),
    .lnk_ld  (lnk_ld_c),
    .lnk_val (lnk_c),
    .snt_ld  (snt_ld_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= ONES_MASK;
      fault_q    <= 1'b0;
      saved_nt_q <= 1'b0;
      ret_kind_q <= RET_NONE;
      link_q     <= '0;
    end else begin
      fault_q    <= op_valid & flt_c;
      ret_kind_q <= op_valid ? ret_c : RET_NONE;
      if (op_valid && ld_c)     flags_q    <= nxt_c;
      if (op_valid && snt_ld_c) saved_nt_q <= flags_q[NT_POS];
      if (op_valid && lnk_ld_c) link_q     <= lnk_c;
    end
  end
endmodule

// File: rtl/flag_guard_chk.sv
module flag_guard_chk
  import flg_pkg::*;
#(
  parameter int                FLAG_W    = 16,
  parameter int                SEL_W     = 16,
  parameter logic [FLAG_W-1:0] ONES_MASK = FLAG_W'(2)
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [1:0]        cpl,
  input logic [SEL_W-1:0]  backlink,
  input logic [FLAG_W-1:0] flags_q,
  input logic              fault_q,
  input logic              saved_nt_q,
  input logic [1:0]        ret_kind_q
);
  logic [1:0] iopl_q;
  logic       popish;
  assign iopl_q = flags_q[IOPL_POS +: 2];
  assign popish = op_valid && (op_code == OP_POP ||
                  (op_code == OP_IRET && !flags_q[NT_POS]));

  AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ONES_MASK) == ONES_MASK); // R2
  AST_IOPL_HOLD: assert property (@(posedge clk) disable iff (rst)
    popish && cpl != 2'd0 |=> flags_q[IOPL_POS +: 2] == $past(flags_q[IOPL_POS +: 2])); // R3
  AST_IF_HOLD: assert property (@(posedge clk) disable iff (rst)
    popish && cpl > iopl_q |=> flags_q[IF_POS] == $past(flags_q[IF_POS])); // R4
  AST_CLI_STI_FAULT: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op_code == OP_CLI || op_code == OP_STI) && cpl > iopl_q
    |=> fault_q && $stable(flags_q)); // R6
  AST_TSW_NT: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_TSW |=> flags_q[NT_POS]); // R7
  AST_INT_NT: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_INT
    |=> !flags_q[NT_POS] && saved_nt_q == $past(flags_q[NT_POS])); // R8
  AST_IRET_TASK: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_IRET && flags_q[NT_POS] && backlink != '0
    |=> ret_kind_q == RET_TASK && $stable(flags_q)); // R10
  AST_IRET_ZERO: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_IRET && flags_q[NT_POS] && backlink == '0
    |=> fault_q && ret_kind_q == RET_NONE && $stable(flags_q)); // R11
  AST_WR_FAULT: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_WR && cpl != 2'd0 |=> fault_q && $stable(flags_q)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !fault_q && $stable(flags_q)); // R13
endmodule

bind flag_guard flag_guard_chk #(
  .FLAG_W(FLAG_W), .SEL_W(SEL_W), .ONES_MASK(ONES_MASK)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .cpl(cpl),
  .backlink(backlink), .flags_q(flags_q), .fault_q(fault_q),
  .saved_nt_q(saved_nt_q), .ret_kind_q(ret_kind_q)
);

// File: tb/flag_guard_tb_top.sv
module flag_guard_tb_top;
  localparam int FW = 16;
  localparam int SW = 16;
  localparam int NV = 13;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  cpl;
    logic [15:0] nf;
    logic [15:0] bl;
    logic [15:0] os;
    logic [15:0] ef;
    logic        flt;
    logic [1:0]  ret;
    logic        snt;
    logic [15:0] lnk;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{3'd7, 2'd0, 16'h1200, 16'h0000, 16'h0000, 16'h1202, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{3'd1, 2'd2, 16'h0085, 16'h0000, 16'h0000, 16'h1287, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{3'd3, 2'd1, 16'h0000, 16'h0000, 16'h0000, 16'h1087, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{3'd4, 2'd3, 16'h0000, 16'h0000, 16'h0000, 16'h1087, 1'b1, 2'd0, 1'b0, 16'h0000},
    '{3'd1, 2'd1, 16'h7201, 16'h0000, 16'h0000, 16'h5203, 1'b0, 2'd0, 1'b0, 16'h0000},
    '{3'd6, 2'd1, 16'h0000, 16'h0000, 16'h0000, 16'h1203, 1'b0, 2'd0, 1'b1, 16'h0000},
    '{3'd2, 2'd0, 16'h3000, 16'h0000, 16'h0000, 16'h3002, 1'b0, 2'd1, 1'b1, 16'h0000},
    '{3'd5, 2'd3, 16'h0200, 16'h0000, 16'h0123, 16'h4202, 1'b0, 2'd0, 1'b1, 16'h0123},
    '{3'd2, 2'd3, 16'h0000, 16'h0000, 16'h0000, 16'h4202, 1'b1, 2'd0, 1'b1, 16'h0123},
    '{3'd2, 2'd3, 16'h0000, 16'h0040, 16'h0000, 16'h4202, 1'b0, 2'd2, 1'b1, 16'h0040},
    '{3'd7, 2'd2, 16'h0000, 16'h0000, 16'h0000, 16'h4202, 1'b1, 2'd0, 1'b1, 16'h0040},
    '{3'd7, 2'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0002, 1'b0, 2'd0, 1'b1, 16'h0040},
    '{3'd4, 2'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0202, 1'b0, 2'd0, 1'b1, 16'h0040}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [1:0]    cpl = '0;
  logic [FW-1:0] new_flags = '0;
  logic [SW-1:0] backlink = '0;
  logic [SW-1:0] old_sel = '0;
  logic [FW-1:0] flags_q;
  logic          fault_q, saved_nt_q;
  logic [1:0]    ret_kind_q;
  logic [SW-1:0] link_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flag_guard #(.FLAG_W(FW), .SEL_W(SW), .ONES_MASK(16'h0002)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .cpl(cpl),
    .new_flags(new_flags), .backlink(backlink), .old_sel(old_sel),
    .flags_q(flags_q), .fault_q(fault_q), .saved_nt_q(saved_nt_q),
    .ret_kind_q(ret_kind_q), .link_q(link_q)
  );

  function automatic string row_tag(int i);
    case (i)
      0:  return "R12";
      1:  return "R3/R4";
      2:  return "R5";
      3:  return "R6";
      4:  return "R2/R3";
      5:  return "R8";
      6:  return "R9";
      7:  return "R7";
      8:  return "R11";
      9:  return "R10";
      10: return "R12";
      11: return "R12";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "flags", 32'(flags_q), 32'h0002);
    check("R1", "fault", 32'(fault_q), 32'h0);
    check("R1", "ret", 32'(ret_kind_q), 32'h0);
    check("R1", "saved_nt", 32'(saved_nt_q), 32'h0);
    check("R1", "link", 32'(link_q), 32'h0);

    for (int i = 0; i < NV; i++) begin
      op_valid  = 1'b1;
      op_code   = TBL[i].op;
      cpl       = TBL[i].cpl;
      new_flags = TBL[i].nf;
      backlink  = TBL[i].bl;
      old_sel   = TBL[i].os;
      @(negedge clk);
      op_valid = 1'b0;
      check(row_tag(i), "flags", 32'(flags_q), 32'(TBL[i].ef));
      check(row_tag(i), "fault", 32'(fault_q), 32'(TBL[i].flt));
      check(row_tag(i), "ret", 32'(ret_kind_q), 32'(TBL[i].ret));
      check(row_tag(i), "saved_nt", 32'(saved_nt_q), 32'(TBL[i].snt));
      check(row_tag(i), "link", 32'(link_q), 32'(TBL[i].lnk));
    end

    // R13: fault pulse from a faulting op is gone after one idle cycle
    op_valid = 1'b1; op_code = 3'd3; cpl = 2'd2;
    @(negedge clk);
    op_valid = 1'b0;
    check("R6", "fault", 32'(fault_q), 32'h1);
    check("R6", "flags", 32'(flags_q), 32'h0202);
    @(negedge clk);
    check("R13", "fault", 32'(fault_q), 32'h0);
    check("R13", "flags", 32'(flags_q), 32'h0202);
    check("R13", "ret", 32'(ret_kind_q), 32'h0);

    // R13: strobe low with a write presented has no effect
    op_code = 3'd7; cpl = 2'd0; new_flags = 16'hFFFF;
    @(negedge clk);
    check("R13", "flags idle", 32'(flags_q), 32'h0202);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "flags", 32'(flags_q), 32'h0002);
    check("R1", "saved_nt", 32'(saved_nt_q), 32'h0);
    check("R1", "link", 32'(link_q), 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule